// File: doc/BRIEF.md
# Periodic Down-Count Interval Timer Channel

This block is a single timer channel that produces a periodic interrupt. A start trigger loads a down-counter from a 32-bit reload register. After that the counter steps down by one on every pulse of a selected count-clock enable. When a step finds the counter at zero, the channel raises a one-cycle interrupt pulse, reloads the counter from the register and keeps running. The interval between interrupts is therefore (reload value + 1) count-clock periods. For example, a reload value of 7999 with an 8 MHz count enable gives a 1 ms period.

The count enable is one of several prescaled clock-enable strobes, chosen by a select input. The channel runs entirely in the system clock domain and uses no gated clocks. A configuration bit can add an interrupt when the start trigger is taken. A stop input halts the channel. Writes to the reload register while the channel runs are picked up at the next reload.

Top module: `ivt_channel`

## Requirements
- R1: On a start trigger (`start_i` high, `stop_i` low) the channel loads the reload register value and begins running. Count-enable pulses in the cycle that the trigger is taken are not counted.
- R2: While running, each pulse on the selected count enable lowers a non-zero count by one. Pulses on the enables that are not selected have no effect on the interrupt timing.
- R3: With reload value D, an interrupt occurs on every (D+1)-th selected pulse after the start. `irq_o` is high for exactly the one cycle that follows the clock edge that sampled the expiring pulse. On that same edge the count reloads.
- R4: `clk_sel_i` = k selects `tick_src_i[k]` as the count enable, for k = 0 to 3.
- R5: When `start_irq_en_i` is 1, a taken start trigger raises `irq_o` in the following cycle. When it is 0, the start trigger raises no interrupt.
- R6: A reload register write made while the channel runs does not change the interval in progress. It sets the length of every interval after the next reload.
- R7: After `stop_i`, the channel raises no interrupt whatever the count enables do. A later start trigger restarts it with a full interval taken from the reload register.
- R8: A reload value of 0 produces an interrupt on every selected pulse.
- R9: After reset, `irq_o` is low, the channel is stopped and the reload register holds 0.
- R10: `stop_i` takes priority over a start trigger in the same cycle. A start trigger while running restarts a full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src_i | input | 4 | Prescaled count-enable strobes, one bit per source |
| clk_sel_i | input | 2 | Index of the count-enable strobe in use |
| start_irq_en_i | input | 1 | 1: interrupt also on the start trigger |
| start_i | input | 1 | Start trigger (load and run) |
| stop_i | input | 1 | Halt the channel |
| data_we_i | input | 1 | Reload register write strobe |
| data_i | input | 32 | Reload register write data |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a reload register write that lands in the middle of an interval. The change only shows up one interval later, so the interrupt timing must be checked across two periods of different lengths. The stimulus starts a channel with a long reload value, writes a short one a few cycles into the first interval, and then checks that the first interrupt comes at the old spacing and the later ones at the new spacing. The sweep varies the select input, the reload value, the start-interrupt bit and the strobe rate. During the sweep it holds every unselected strobe high, so any leakage from the wrong source changes the interrupt pattern.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] tick_src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = (sel_i == SEL_W'(g)) && tick_src_i[g];
    end

    assign tick_o = |hit;

    // A strobe may pass only when the source it came from is the selected one.
    always_comb begin
        if (tick_o) begin
            assert_tick_from_selected_R4: assert (tick_src_i[sel_i])
                else $error("tick passed from an unselected source");
        end
    end

endmodule

// File: rtl/ivt_data_reg.sv
module ivt_data_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (we_i) data_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

    // The written value must be the one held after the write edge.
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> data_o == $past(wdata_i));

endmodule

// File: rtl/ivt_count_core.sv
module ivt_count_core
    import ivt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         start_irq_en_i,
    input  logic [W-1:0] reload_i,
    output logic         irq_o
);

    typedef struct packed {
        ch_state_e    st;
        logic [W-1:0] cnt;
        logic         irq;
    } core_s;

    core_s core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.irq = 1'b0;
        if (stop_i) begin
            core_d.st = CH_IDLE;
        end else if (start_i) begin
            core_d.st  = CH_RUN;
            core_d.cnt = reload_i;
            core_d.irq = start_irq_en_i;
        end else if (core_q.st == CH_RUN && tick_i) begin
            if (core_q.cnt == '0) begin
                core_d.cnt = reload_i;
                core_d.irq = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{st: CH_IDLE, cnt: '0, irq: 1'b0};
        else        core_q <= core_d;
    end

    assign irq_o = core_q.irq;

    assert_start_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (core_q.cnt == $past(reload_i)) && (core_q.st == CH_RUN));

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == CH_RUN && tick_i && !start_i && !stop_i && core_q.cnt != '0)
        |=> (core_q.cnt == $past(core_q.cnt) - 1'b1) && !irq_o);

    assert_expire_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == CH_RUN && tick_i && !start_i && !stop_i && core_q.cnt == '0)
        |=> irq_o && (core_q.cnt == $past(reload_i)));

    assert_start_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> irq_o == $past(start_irq_en_i));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == CH_IDLE && !start_i) |=> !irq_o);

    assert_stop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (core_q.st == CH_IDLE) && !irq_o);

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel #(
    parameter int CNT_W   = 32,
    parameter int NUM_CLK = 4,
    parameter int SEL_W   = $clog2(NUM_CLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] tick_src_i,
    input  logic [SEL_W-1:0]   clk_sel_i,
    input  logic               start_irq_en_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               data_we_i,
    input  logic [CNT_W-1:0]   data_i,
    output logic               irq_o
);

    logic             tick;
    logic [CNT_W-1:0] reload;

    ivt_tick_sel #(.NUM_SRC(NUM_CLK), .SEL_W(SEL_W)) u_tick_sel (
        .tick_src_i (tick_src_i),
        .sel_i      (clk_sel_i),
        .tick_o     (tick)
    );

    ivt_data_reg #(.W(CNT_W)) u_data_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (data_we_i),
        .wdata_i (data_i),
        .data_o  (reload)
    );

    ivt_count_core #(.W(CNT_W)) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .start_i        (start_i),
        .stop_i         (stop_i),
        .start_irq_en_i (start_irq_en_i),
        .reload_i       (reload),
        .irq_o          (irq_o)
    );

    // Reset state: no interrupt in the first cycle after reset release.
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);

endmodule

// File: tb/ivt_channel_tb.sv
module ivt_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = 4'h0;
    logic [1:0]  clk_sel = 2'd0;
    logic        sie = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_channel u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_src_i     (tick_src),
        .clk_sel_i      (clk_sel),
        .start_irq_en_i (sie),
        .start_i        (start),
        .stop_i         (stop),
        .data_we_i      (we),
        .data_i         (wdata),
        .irq_o          (irq)
    );

    task automatic check(input logic act, input logic exp, input string req, input int j);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: irq actual %b expected %b", req, j, act, exp);
        end
    endtask

    // Drive one cycle's inputs after a falling edge, then return after the next falling edge.
    task automatic step(input logic [3:0] tk, input logic st, input logic sp,
                        input logic w, input logic [31:0] wd);
        tick_src = tk; start = st; stop = sp; we = w; wdata = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Sweep case: reload D, selected source strobes every P cycles, others held high.
    task automatic run_case(input int sel, input int d, input bit s_irq, input int p);
        logic [3:0] tk;
        int per;
        int len;
        clk_sel = 2'(sel);
        sie = s_irq;
        step(4'h0, 1'b0, 1'b1, 1'b1, 32'(d));
        per = (d + 1) * p;
        len = 3 * per + 1;
        for (int j = 0; j <= len; j++) begin
            tk = 4'hF;
            tk[sel] = (j != 0) && (j % p == 0);
            step(tk, j == 0, 1'b0, 1'b0, 32'd0);
            if (j == 0)
                check(irq, s_irq, "R5 start interrupt (R1 load)", j);
            else if (d == 0)
                check(irq, (j % p == 0), "R8 every-tick (R4 select)", j);
            else
                check(irq, (j % per == 0), "R3/R4 period (R2 ignore unselected)", j);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq, 1'b0, "R9 reset irq", 0);
        for (int j = 1; j <= 5; j++) begin
            step(4'hF, 1'b0, 1'b0, 1'b0, 32'd0);
            check(irq, 1'b0, "R9 idle after reset", j);
        end
        // Reload register reset value 0: start with no write gives an interrupt per tick.
        clk_sel = 2'd2;
        sie = 1'b0;
        step(4'hF, 1'b1, 1'b0, 1'b0, 32'd0);
        check(irq, 1'b0, "R9 start no irq", 0);
        for (int j = 1; j <= 4; j++) begin
            step(4'hF, 1'b0, 1'b0, 1'b0, 32'd0);
            check(irq, 1'b1, "R9 reload reset zero", j);
        end

        // Sweep over select, reload value, start interrupt and strobe rate.
        for (int sel = 0; sel < 4; sel++)
            for (int di = 0; di < 4; di++)
                for (int s = 0; s < 2; s++)
                    for (int pi = 0; pi < 2; pi++)
                        run_case(sel, (di == 3) ? 5 : di, s[0], (pi == 0) ? 1 : 3);

        // R6: write during an interval, new value used from the next reload.
        clk_sel = 2'd1;
        sie = 1'b0;
        step(4'h0, 1'b0, 1'b1, 1'b1, 32'd3);
        for (int j = 0; j <= 10; j++) begin
            step(4'hF, j == 0, 1'b0, j == 2, 32'd1);
            if (j > 0)
                check(irq, (j == 4) || (j == 6) || (j == 8) || (j == 10), "R6 mid-run write", j);
        end

        // R7: stop halts, ticks ignored, restart gives a full interval.
        step(4'h0, 1'b0, 1'b1, 1'b1, 32'd4);
        for (int j = 0; j <= 30; j++) begin
            step(4'hF, (j == 0) || (j == 21), j == 4, 1'b0, 32'd0);
            if (j > 0)
                check(irq, j == 26, "R7 stop and restart", j);
        end

        // R10: restart while running, then stop beats a simultaneous start.
        step(4'h0, 1'b0, 1'b1, 1'b1, 32'd3);
        for (int j = 0; j <= 8; j++) begin
            step(4'hF, (j == 0) || (j == 2), 1'b0, 1'b0, 32'd0);
            if (j > 0)
                check(irq, j == 6, "R10 restart while running", j);
        end
        sie = 1'b1;
        for (int j = 0; j <= 10; j++) begin
            step(4'hF, j == 0, j == 0, 1'b0, 32'd0);
            check(irq, 1'b0, "R10 stop beats start", j);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule